// File: doc/BRIEF.md
# Memory-Mapped Eight-Pin GPIO with Interrupt Sensing

This block is an eight-pin general-purpose I/O peripheral on a simple APB-style register bus. Each pin can be an input or an output. Pin data is reached through an address window in which address bits select which pins an access touches. A single pin can therefore be set or cleared with one write, with no read-modify-write. The pins leave the block as separate input, output and output-enable vectors. Pads and pin multiplexing are outside it.

Every pin has its own interrupt detector. The detector can watch a level (high or low) or an edge (rising or falling), and a both-edges option makes it fire on any change. Latched edge status is cleared by writing ones to a clear register. The raw status is gated by a per-pin enable to form the masked status, and all masked bits are ORed onto one interrupt line. Fixed identification bytes let software recognise the peripheral.

Top module: `gpio_sense_bank`

## Requirements
- R1: After reset, the output-enable vector, the output vector, the interrupt line and every control register (read at offsets 0x400, 0x404, 0x408, 0x40C, 0x410) are zero. Writing the direction register at 0x400 drives the output-enable vector, where bit value 1 means output.
- R2: A write to an address in 0x000–0x3FC uses address bits [9:2] as a pin mask. Only output bits whose mask bit is 1 take the written data.
- R3: A read in 0x000–0x3FC returns, for each pin, the driven value if the pin is an output and the synchronized input if it is an input, ANDed with the mask in address bits [9:2]. Bits outside the mask read as zero.
- R4: A data write to a pin whose direction bit is 0 leaves that pin's stored output value unchanged. The stored value becomes visible only once the pin is switched to output.
- R5: With the sense bit (0x404) at 0 and the both-edges bit (0x408) at 0, a pin latches raw status on a rising input edge when its event bit (0x40C) is 1, and on a falling edge when it is 0. The other edge is ignored.
- R6: With the both-edges bit at 1 in edge mode, both edges latch status whatever the event bit holds.
- R7: With the sense bit at 1, raw status follows the synchronized pin level: it is set while the level is high if the event bit is 1, and while it is low if the event bit is 0. It is not latched, and the clear register does not affect it.
- R8: The masked status (0x418) equals the raw status (0x414) ANDed with the enable register (0x410). The interrupt line is high exactly when some masked bit is 1.
- R9: Writing a 1 to a bit of the clear register (0x41C) clears that pin's latched edge status, and writing a 0 leaves it alone. If a clear and a new edge on the same pin land in the same cycle, the status stays set.
- R10: Reads at 0xFE0, 0xFE4, 0xFE8 and 0xFEC return the identification bytes 0x61, 0x10, 0x04 and 0x00, which form the word 0x00041061 with the least significant byte first.
- R11: The direction, sense, both-edges, event and enable registers read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid while selected |
| pinIn | input | 8 | Pin input levels (asynchronous) |
| pinOut | output | 8 | Pin output values |
| pinOe | output | 8 | Pin output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a clear write that completes in the same clock as a new edge reaching the latch on the same pin. That edge has to pass three registers (two synchronizer stages and the previous-value stage) first. The bench changes the pin on a falling clock edge and then starts a two-phase bus write on the next falling edge. The access phase of the write then closes on exactly the rising edge where the latch captures the edge. Reading raw status afterwards shows whether the edge won.

// File: rtl/gsb_pkg.sv
package gsb_pkg;
  localparam int NPIN = 8;
  localparam int AW   = 12;

  typedef enum logic [3:0] {
    RD_NONE, RD_DATA, RD_DIR, RD_SENSE, RD_BOTH, RD_EVENT,
    RD_EN, RD_RAW, RD_MASKED, RD_ID
  } rdSel_e;

  typedef struct packed {
    logic            wrData;
    logic            wrDir;
    logic            wrSense;
    logic            wrBoth;
    logic            wrEvent;
    logic            wrEn;
    logic            wrClr;
    rdSel_e          rdSel;
    logic [NPIN-1:0] pinMask;
    logic [1:0]      idIdx;
  } ctrlStrb_t;
endpackage

// File: rtl/gsb_ctrl.sv
module gsb_ctrl
  import gsb_pkg::*;
(
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  output ctrlStrb_t     strb
);
  localparam int WIDX = AW - 2;
  localparam logic [WIDX-1:0] REG_BASE = WIDX'(10'h100);
  localparam logic [WIDX-1:0] ID_BASE  = WIDX'(10'h3F8);

  logic [WIDX-1:0] wIdx;
  logic            aligned, wrAct, hitData, hitReg, hitId;

  assign wIdx    = paddr[AW-1:2];
  assign aligned = (paddr[1:0] == 2'b00);
  assign wrAct   = psel && penable && pwrite && aligned;
  assign hitData = (wIdx[WIDX-1:NPIN] == '0);
  assign hitReg  = (wIdx[WIDX-1:3] == REG_BASE[WIDX-1:3]);
  assign hitId   = (wIdx[WIDX-1:2] == ID_BASE[WIDX-1:2]);

  always_comb begin
    strb         = '0;
    strb.rdSel   = RD_NONE;
    strb.pinMask = paddr[NPIN+1:2];
    strb.idIdx   = paddr[3:2];
    if (hitData) begin
      strb.rdSel  = RD_DATA;
      strb.wrData = wrAct;
    end else if (hitReg) begin
      unique case (wIdx[2:0])
        3'd0: begin strb.rdSel = RD_DIR;    strb.wrDir   = wrAct; end
        3'd1: begin strb.rdSel = RD_SENSE;  strb.wrSense = wrAct; end
        3'd2: begin strb.rdSel = RD_BOTH;   strb.wrBoth  = wrAct; end
        3'd3: begin strb.rdSel = RD_EVENT;  strb.wrEvent = wrAct; end
        3'd4: begin strb.rdSel = RD_EN;     strb.wrEn    = wrAct; end
        3'd5: strb.rdSel = RD_RAW;
        3'd6: strb.rdSel = RD_MASKED;
        default: strb.wrClr = wrAct;
      endcase
    end else if (hitId) begin
      strb.rdSel = RD_ID;
    end
    if (!(psel && aligned)) strb.rdSel = RD_NONE;
  end
endmodule

// File: rtl/gsb_datapath.sv
module gsb_datapath
  import gsb_pkg::*;
#(
  parameter logic [31:0] PERIPH_ID = 32'h0004_1061
)(
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrb_t       strb,
  input  logic [7:0]      pwdata,
  output logic [7:0]      prdata,
  input  logic [NPIN-1:0] pinIn,
  output logic [NPIN-1:0] pinOut,
  output logic [NPIN-1:0] pinOe,
  output logic            irq
);
  logic [NPIN-1:0] dirReg, dataReg, senseReg, bothReg, eventReg, enReg;
  logic [NPIN-1:0] edgeLatch, syncA, syncB, prevB;
  logic [NPIN-1:0] edgeHit, levelHit, rawStat, maskStat, setMask, clrMask;
  logic [NPIN-1:0] pinVal;
  logic [31:0]     idWord;

  // two-flop synchronizer plus one history stage for edge finding
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0; syncB <= '0; prevB <= '0;
    end else begin
      syncA <= pinIn; syncB <= syncA; prevB <= syncB;
    end
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic rise, fall;
    assign rise        = syncB[i] & ~prevB[i];
    assign fall        = ~syncB[i] & prevB[i];
    assign edgeHit[i]  = bothReg[i] ? (rise | fall) : (eventReg[i] ? rise : fall);
    assign levelHit[i] = eventReg[i] ? syncB[i] : ~syncB[i];
    assign rawStat[i]  = senseReg[i] ? levelHit[i] : edgeLatch[i];
  end

  assign setMask  = edgeHit & ~senseReg;
  assign clrMask  = strb.wrClr ? pwdata[NPIN-1:0] : '0;
  assign maskStat = rawStat & enReg;
  assign irq      = |maskStat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '0; dataReg <= '0; senseReg <= '0; bothReg <= '0;
      eventReg <= '0; enReg <= '0; edgeLatch <= '0;
    end else begin
      if (strb.wrDir)   dirReg   <= pwdata[NPIN-1:0];
      if (strb.wrSense) senseReg <= pwdata[NPIN-1:0];
      if (strb.wrBoth)  bothReg  <= pwdata[NPIN-1:0];
      if (strb.wrEvent) eventReg <= pwdata[NPIN-1:0];
      if (strb.wrEn)    enReg    <= pwdata[NPIN-1:0];
      if (strb.wrData) begin
        dataReg <= (dataReg & ~(strb.pinMask & dirReg)) |
                   (pwdata[NPIN-1:0] & strb.pinMask & dirReg);
      end
      // a new edge overrides a clear landing in the same cycle
      edgeLatch <= (edgeLatch & ~clrMask) | setMask;
    end
  end

  assign pinOut = dataReg;
  assign pinOe  = dirReg;
  assign pinVal = (dirReg & dataReg) | (~dirReg & syncB);
  assign idWord = PERIPH_ID >> {strb.idIdx, 3'b000};

  always_comb begin
    unique case (strb.rdSel)
      RD_DATA:   prdata = pinVal & strb.pinMask;
      RD_DIR:    prdata = dirReg;
      RD_SENSE:  prdata = senseReg;
      RD_BOTH:   prdata = bothReg;
      RD_EVENT:  prdata = eventReg;
      RD_EN:     prdata = enReg;
      RD_RAW:    prdata = rawStat;
      RD_MASKED: prdata = maskStat;
      RD_ID:     prdata = idWord[7:0];
      default:   prdata = '0;
    endcase
  end

  // R2: unmasked pins keep their stored value across a data write
  p_masked_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData |=> (((dataReg ^ $past(dataReg)) & ~$past(strb.pinMask)) == '0));

  // R4: pins that are inputs ignore data writes
  p_input_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrData |=> (((dataReg ^ $past(dataReg)) & ~$past(dirReg)) == '0));

  // R9: latched status only appears after a detected edge
  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((edgeLatch & ~$past(edgeLatch) & ~$past(setMask)) == '0));

  // R9: an edge arriving with a clear is kept
  p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> ((edgeLatch & $past(setMask)) == $past(setMask)));

  // R8: no interrupt while every enable is off
  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    (enReg == '0) |-> !irq);
endmodule

// File: rtl/gpio_sense_bank.sv
module gpio_sense_bank
  import gsb_pkg::*;
#(
  parameter logic [31:0] PERIPH_ID = 32'h0004_1061
)(
  input  logic            clk,
  input  logic            rstN,
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [AW-1:0]   paddr,
  input  logic [7:0]      pwdata,
  output logic [7:0]      prdata,
  input  logic [NPIN-1:0] pinIn,
  output logic [NPIN-1:0] pinOut,
  output logic [NPIN-1:0] pinOe,
  output logic            irq
);
  ctrlStrb_t strb;

  gsb_ctrl u_ctrl (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .strb(strb)
  );

  gsb_datapath #(.PERIPH_ID(PERIPH_ID)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pwdata(pwdata), .prdata(prdata),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  // R1: output enables move only after a completed write to the direction offset
  p_oe_by_dir_r1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(psel && penable && pwrite && paddr == 12'h400) |-> $stable(pinOe));
endmodule

// File: tb/sim_gpio_sense_bank.sv
module sim_gpio_sense_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [7:0]  pwdata = '0;
  logic [7:0]  prdata;
  logic [7:0]  pinIn = '0;
  logic [7:0]  pinOut, pinOe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] expQ[$];
  string      tagQ[$];
  event       sampleEv;

  always #10 clk = ~clk;

  gpio_sense_bank u0 (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irq(irq)
  );

  // scoreboard monitor: compare each bus read against the queued expectation
  initial begin
    forever begin
      @(sampleEv);
      if (expQ.size() > 0) begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checks++;
        if (prdata !== e) begin
          errors++;
          $display("FAIL %s read act=%02h exp=%02h", t, prdata, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%02h exp=%02h", t, act, exp);
    end
  endtask

  task automatic busWr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(posedge clk);
    #2 psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic busRd(input logic [11:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(t);
    #5 -> sampleEv;
    @(posedge clk);
    #2 psel = 1'b0; penable = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog act=00 exp=01");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 oe after reset", pinOe, 8'h00);
    chk("R1 out after reset", pinOut, 8'h00);
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    busRd(12'h400, 8'h00, "R1 dir reset");
    busRd(12'h410, 8'h00, "R1 enable reset");
    busRd(12'h404, 8'h00, "R1 sense reset");
    // R10 identification
    busRd(12'hFE0, 8'h61, "R10 id0");
    busRd(12'hFE4, 8'h10, "R10 id1");
    busRd(12'hFE8, 8'h04, "R10 id2");
    busRd(12'hFEC, 8'h00, "R10 id3");
    // R1 / R11 direction and config readback
    busWr(12'h400, 8'hF0);
    busRd(12'h400, 8'hF0, "R11 dir readback");
    chk("R1 oe follows dir", pinOe, 8'hF0);
    // R2 masked writes
    busWr(12'h3FC, 8'hA5);
    chk("R2 full mask write", pinOut, 8'hA0);
    busWr(12'h0C0, 8'hFF);
    chk("R2 partial mask write", pinOut, 8'hB0);
    // R4 write to input pin ignored
    busWr(12'h004, 8'hFF);
    busWr(12'h400, 8'hF1);
    chk("R4 input pin kept old value", pinOut, 8'hB0);
    // R3 masked reads
    @(negedge clk); pinIn = 8'h0E;
    settle();
    busRd(12'h3FC, 8'hBE, "R3 read all pins");
    busRd(12'h030, 8'h0C, "R3 read inputs masked");
    busRd(12'h200, 8'h80, "R3 read output masked");
    busRd(12'h104, 8'h00, "R3 unmasked zero");
    // interrupt configuration, all pins inputs
    busWr(12'h400, 8'h00);
    @(negedge clk); pinIn = 8'h00;
    busWr(12'h404, 8'h80);
    busWr(12'h40C, 8'h81);
    busWr(12'h408, 8'h04);
    busRd(12'h404, 8'h80, "R11 sense readback");
    busRd(12'h40C, 8'h81, "R11 event readback");
    busRd(12'h408, 8'h04, "R11 both readback");
    settle();
    busWr(12'h41C, 8'hFF);
    busRd(12'h414, 8'h00, "R9 clear all latched");
    // R5 rising on pin0
    @(negedge clk); pinIn = 8'h01;
    settle();
    busRd(12'h414, 8'h01, "R5 rising latched");
    busRd(12'h418, 8'h00, "R8 masked with enables off");
    chk("R8 irq off without enable", {7'd0, irq}, 8'h00);
    busWr(12'h410, 8'h01);
    busRd(12'h410, 8'h01, "R11 enable readback");
    chk("R8 irq with enable", {7'd0, irq}, 8'h01);
    busRd(12'h418, 8'h01, "R8 masked status");
    // R9 clear semantics
    busWr(12'h41C, 8'h00);
    busRd(12'h414, 8'h01, "R9 zero clear ignored");
    busWr(12'h41C, 8'h01);
    busRd(12'h414, 8'h00, "R9 one clears");
    chk("R9 irq drops after clear", {7'd0, irq}, 8'h00);
    // R5 falling on pin1, rise ignored
    @(negedge clk); pinIn = 8'h03;
    settle();
    busRd(12'h414, 8'h00, "R5 rise ignored on falling pin");
    @(negedge clk); pinIn = 8'h00;
    settle();
    busRd(12'h414, 8'h02, "R5 falling latched, pin0 fall ignored");
    busWr(12'h41C, 8'h02);
    // R6 both edges on pin2
    @(negedge clk); pinIn = 8'h04;
    settle();
    busRd(12'h414, 8'h04, "R6 both-edge rise");
    busWr(12'h41C, 8'h04);
    busRd(12'h414, 8'h00, "R6 cleared");
    @(negedge clk); pinIn = 8'h00;
    settle();
    busRd(12'h414, 8'h04, "R6 both-edge fall");
    busWr(12'h41C, 8'h04);
    // R7 level mode on pin7
    @(negedge clk); pinIn = 8'h80;
    settle();
    busRd(12'h414, 8'h80, "R7 level high seen");
    busWr(12'h41C, 8'h80);
    busRd(12'h414, 8'h80, "R7 clear has no effect");
    busWr(12'h410, 8'h80);
    chk("R7 irq from level", {7'd0, irq}, 8'h01);
    @(negedge clk); pinIn = 8'h00;
    settle();
    busRd(12'h414, 8'h00, "R7 level low drops status");
    chk("R7 irq drops", {7'd0, irq}, 8'h00);
    // R9 clear and new edge in the same cycle
    @(negedge clk); pinIn = 8'h04;
    settle();
    busWr(12'h41C, 8'h04);
    busRd(12'h414, 8'h00, "R9 pre-race cleared");
    settle();
    busWr(12'h41C, 8'h00);
    @(negedge clk); pinIn = 8'h00;
    busWr(12'h41C, 8'h04);
    busRd(12'h414, 8'h04, "R9 edge wins over clear");
    settle();
    wait (expQ.size() == 0);
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule